// File: doc/BRIEF.md
# Pin-Routed Synchronous Serial Transmitter

This cell sits beside one I/O pin in a pin bank. It shifts a loaded word out on its own pin, one bit per falling edge of a shift clock. The shift clock is not a dedicated port. It is picked from a seven-pin window centred on the cell, or from the host's OUT bit, through a 4-bit selector. The top bit of the selector inverts the chosen source. A second selector of the same form picks the A input. A small combiner can then merge A and B with AND, OR or XOR. When the cell is off, the combined A level is what the host reads as the pin input.

A 24-bit control word sets up the cell. It holds the operating mode, the output-enable override, the combiner code, both selectors, the word length and the bit order. The host loads data, reads status and can acknowledge the done flag. While the transmit mode is selected, the shifter output replaces the host's OUT bit and the override field replaces the host's DIR.

Top module: `pin_sync_tx`

## Requirements
- R1: With mode field 0, the cell is held cleared: pinOut follows hostOut, pinOe follows hostDir, pinIn shows the combined A level, and statDone stays 0.
- R2: The low three bits of a selector pick its source. Code 0 is the own pin, nearPins[3]. Codes 1, 2 and 3 are the pins +1, +2 and +3 (nearPins[4..6]). Code 4 is hostOut. Codes 5, 6 and 7 are the pins -3, -2 and -1 (nearPins[0..2]).
- R3: Selector bit 3 set inverts the chosen source. B selector 4'b0111 takes the clock from nearPins[2], and 4'b1111 takes the same pin inverted.
- R4: The combine code changes only A. Code 1 gives A AND B, code 2 gives A OR B, code 3 gives A XOR B. Codes 0 and 4 to 7 pass A through unchanged.
- R5: With a nonzero mode, pinOe equals bit 0 of the override field, whatever hostDir is.
- R6: Mode 5'b11100 selects transmit. pinOut then carries the shifter bit, never hostOut. The first bit appears one cycle after a dataWr that is accepted.
- R7: A falling edge of the selected B level moves the output to the next bit. A rising edge leaves the output unchanged.
- R8: The order bit (cfgWord[23]) set sends the word MSB first. 8'h71 then gives 0,1,1,1,0,0,0,1. With the bit clear the same word gives 1,0,0,0,1,1,1,0.
- R9: cfgWord[22:18] holds the word length minus one, so 1 to 32 bits. statDone rises on the falling edge that follows the last bit, and pinOut then holds the last bit until the next load.
- R10: A dataWr issued while a word is still shifting is ignored. The sequence already under way is unchanged.
- R11: A statRd pulse or a statAck pulse clears statDone.
- R12: In transmit mode, pinIn shows statDone.

Control word layout: [4:0] mode, [6:5] override, [9:7] combine, [13:10] A selector, [17:14] B selector, [22:18] length minus one, [23] order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nearPins | input | 7 | Read levels of pins -3..+3; bit 3 is the own pin |
| hostOut | input | 1 | Host OUT bit |
| hostDir | input | 1 | Host DIR bit |
| cfgWr | input | 1 | Write strobe for cfgWord |
| cfgWord | input | 24 | Control word |
| dataWr | input | 1 | Load strobe for dataIn |
| dataIn | input | 32 | Word to transmit |
| statRd | input | 1 | Status read; clears done |
| statAck | input | 1 | Explicit acknowledge; clears done |
| pinOut | output | 1 | Level driven to the pin |
| pinOe | output | 1 | Pin driver enable |
| pinIn | output | 1 | Input seen by host (combined A, or done in transmit mode) |
| statDone | output | 1 | Word-finished flag |

## Verification
The selectors are swept over all eight codes, with and without inversion, on two asymmetric pin patterns and both hostOut levels. A wrong offset or a mirrored window therefore reads a different level. Every combine code runs against all four A/B pairs, which separates AND, OR, XOR and pass-through. The word 8'h71 is sent in both orders, because it is not a palindrome and so exposes reversed shifting. A one-bit word and 32-bit words, one of them sent with an inverted clock, test the length count at both limits and show that only the falling B edge advances. A load attempted mid-word and both ways of clearing done finish the set.

// File: rtl/pin_sync_tx_pkg.sv
package pin_sync_tx_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int SEL_W  = 4;
  localparam int CMB_W  = 3;
  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_OFF     = 5'b00000;
  localparam logic [MODE_W-1:0] MODE_SYNC_TX = 5'b11100;

  localparam logic [CMB_W-1:0] CMB_AND = 3'b001;
  localparam logic [CMB_W-1:0] CMB_OR  = 3'b010;
  localparam logic [CMB_W-1:0] CMB_XOR = 3'b011;

  typedef struct packed {
    logic              msbFirst;
    logic [LEN_W-1:0]  lenM1;
    logic [SEL_W-1:0]  bSel;
    logic [SEL_W-1:0]  aSel;
    logic [CMB_W-1:0]  comb;
    logic [1:0]        oeCtl;
    logic [MODE_W-1:0] mode;
  } cellCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic shift;
  } shCtl_t;
endpackage

// File: rtl/pst_router.sv
module pst_router
  import pin_sync_tx_pkg::*;
#(
  parameter int REACH = 3,
  localparam int WIN = 2 * REACH + 1
) (
  input  logic [WIN-1:0]   nearPins,
  input  logic             hostOut,
  input  logic [SEL_W-1:0] aSel,
  input  logic [SEL_W-1:0] bSel,
  input  logic [CMB_W-1:0] comb,
  output logic             aRes,
  output logic             bRes
);
  logic [SEL_W-1:0] selArr [2];
  logic [1:0]       picked;

  assign selArr[0] = aSel;
  assign selArr[1] = bSel;

  for (genvar g = 0; g < 2; g++) begin : g_sel
    logic raw;
    always_comb begin
      unique case (selArr[g][2:0])
        3'd0: raw = nearPins[REACH];
        3'd1: raw = nearPins[REACH+1];
        3'd2: raw = nearPins[REACH+2];
        3'd3: raw = nearPins[REACH+3];
        3'd4: raw = hostOut;
        3'd5: raw = nearPins[REACH-3];
        3'd6: raw = nearPins[REACH-2];
        default: raw = nearPins[REACH-1];
      endcase
    end
    assign picked[g] = raw ^ selArr[g][SEL_W-1];
  end

  always_comb begin
    unique case (comb)
      CMB_AND: aRes = picked[0] & picked[1];
      CMB_OR:  aRes = picked[0] | picked[1];
      CMB_XOR: aRes = picked[0] ^ picked[1];
      default: aRes = picked[0];
    endcase
  end

  assign bRes = picked[1];
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pin_sync_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             bRes,
  input  logic             dataWr,
  input  logic [LEN_W-1:0] lenM1,
  input  logic             statClr,
  output shCtl_t           ctl,
  output logic             busy,
  output logic             done,
  output logic             clkFall
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   bPrev;
  logic [CNT_W-1:0]       remain;
  logic                   loadOk;
  logic                   finish;

  assign clkFall = bPrev & ~syncQ[SYNC_STAGES-1];
  assign loadOk  = enable & dataWr & ~busy;
  assign finish  = busy & clkFall & (remain == CNT_W'(1));

  assign ctl.clear = ~enable;
  assign ctl.load  = loadOk;
  assign ctl.shift = busy & clkFall & (remain != CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      bPrev <= 1'b0;
    end else if (!enable) begin
      syncQ <= '0;
      bPrev <= 1'b0;
    end else begin
      syncQ <= SYNC_STAGES'({syncQ, bRes});
      bPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (!enable) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (loadOk) begin
        remain <= {1'b0, lenM1} + CNT_W'(1);
        busy   <= 1'b1;
        done   <= 1'b0;
      end else if (busy && clkFall) begin
        remain <= remain - CNT_W'(1);
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (statClr) begin
        done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pst_shifter.sv
module pst_shifter
  import pin_sync_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  shCtl_t            ctl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              msbFirst,
  output logic              txBit
);
  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] shReg;
  logic              msbReg;
  logic [LEN_W-1:0]  alignAmt;

  assign alignAmt = TOP_IDX - lenM1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      msbReg <= 1'b0;
    end else if (ctl.clear) begin
      shReg  <= '0;
      msbReg <= 1'b0;
    end else if (ctl.load) begin
      msbReg <= msbFirst;
      shReg  <= msbFirst ? (dataIn << alignAmt) : dataIn;
    end else if (ctl.shift) begin
      shReg  <= msbReg ? (shReg << 1) : (shReg >> 1);
    end
  end

  assign txBit = msbReg ? shReg[DATA_W-1] : shReg[0];
endmodule

// File: rtl/pin_sync_tx.sv
module pin_sync_tx
  import pin_sync_tx_pkg::*;
#(
  parameter int REACH = 3,
  parameter int SYNC_STAGES = 2,
  localparam int WIN = 2 * REACH + 1,
  localparam int CFG_W = $bits(cellCfg_t)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIN-1:0]    nearPins,
  input  logic              hostOut,
  input  logic              hostDir,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              statRd,
  input  logic              statAck,
  output logic              pinOut,
  output logic              pinOe,
  output logic              pinIn,
  output logic              statDone
);
  cellCfg_t cfgReg;
  shCtl_t   ctl;
  logic     aRes, bRes, busy, done, clkFall, txBit;
  logic     active, smartOn;
  logic     unusedOeHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWr) cfgReg <= cellCfg_t'(cfgWord);
  end

  assign active     = (cfgReg.mode == MODE_SYNC_TX);
  assign smartOn    = (cfgReg.mode != MODE_OFF);
  assign unusedOeHi = cfgReg.oeCtl[1];

  pst_router #(.REACH(REACH)) u_router (
    .nearPins(nearPins), .hostOut(hostOut),
    .aSel(cfgReg.aSel), .bSel(cfgReg.bSel), .comb(cfgReg.comb),
    .aRes(aRes), .bRes(bRes)
  );

  pst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(active), .bRes(bRes),
    .dataWr(dataWr), .lenM1(cfgReg.lenM1), .statClr(statRd | statAck),
    .ctl(ctl), .busy(busy), .done(done), .clkFall(clkFall)
  );

  pst_shifter u_shift (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .lenM1(cfgReg.lenM1), .msbFirst(cfgReg.msbFirst), .txBit(txBit)
  );

  assign pinOut   = active ? txBit : hostOut;
  assign pinOe    = smartOn ? cfgReg.oeCtl[0] : hostDir;
  assign pinIn    = active ? done : aRes;
  assign statDone = done;
endmodule

// File: rtl/pst_chk.sv
module pst_chk (
  input logic clk,
  input logic rstN,
  input logic active,
  input logic busy,
  input logic clkFall,
  input logic dataWr,
  input logic cfgWr,
  input logic statRd,
  input logic statAck,
  input logic pinOut,
  input logic statDone
);
  // R1
  off_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !statDone);

  // R7
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && !clkFall && !dataWr && !cfgWr |=> $stable(pinOut));

  // R9
  done_after_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statDone) |-> $past(clkFall));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    statDone |-> !busy);

  // R10
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    active && busy && dataWr && !clkFall && !cfgWr |=> $stable(pinOut));

  // R11
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRd || statAck) && !busy |=> !statDone);
endmodule

bind pin_sync_tx pst_chk u_chk (
  .clk(clk), .rstN(rstN), .active(active), .busy(busy), .clkFall(clkFall),
  .dataWr(dataWr), .cfgWr(cfgWr), .statRd(statRd), .statAck(statAck),
  .pinOut(pinOut), .statDone(statDone)
);

// File: tb/tb_pin_sync_tx.sv
module tb_pin_sync_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  nearPins = 7'b0000100;
  logic        hostOut = 1'b0, hostDir = 1'b0;
  logic        cfgWr = 1'b0, dataWr = 1'b0, statRd = 1'b0, statAck = 1'b0;
  logic [23:0] cfgWord = '0;
  logic [31:0] dataIn = '0;
  logic        pinOut, pinOe, pinIn, statDone;
  logic        bInv = 1'b0;
  int nChecks = 0, nFails = 0;

  localparam logic [4:0] TX = 5'b11100;

  always #10 clk = ~clk;

  pin_sync_tx dut (
    .clk(clk), .rstN(rstN), .nearPins(nearPins), .hostOut(hostOut), .hostDir(hostDir),
    .cfgWr(cfgWr), .cfgWord(cfgWord), .dataWr(dataWr), .dataIn(dataIn),
    .statRd(statRd), .statAck(statAck), .pinOut(pinOut), .pinOe(pinOe),
    .pinIn(pinIn), .statDone(statDone)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] mkCfg(logic [4:0] mode, logic [1:0] oe, logic [2:0] comb,
                                        logic [3:0] a, logic [3:0] b, logic [4:0] lenM1, logic msb);
    return {msb, lenM1, b, a, comb, oe, mode};
  endfunction

  function automatic logic selRef(logic [3:0] s, logic [6:0] np, logic ho);
    logic v;
    if (s[2:0] == 3'd4) v = ho;
    else if (s[2:0] < 3'd4) v = np[3 + s[2:0]];
    else v = np[s[2:0] - 3'd5];
    return v ^ s[3];
  endfunction

  task automatic writeCfg(logic [23:0] w);
    cfgWord = w; cfgWr = 1'b1; step(1); cfgWr = 1'b0;
  endtask

  task automatic bFall(); nearPins[2] = bInv;  step(4); endtask
  task automatic bRise(); nearPins[2] = ~bInv; step(4); endtask

  task automatic loadWord(logic [31:0] d);
    dataIn = d; dataWr = 1'b1; step(1); dataWr = 1'b0;
  endtask

  task automatic enterTx(logic [4:0] lenM1, logic msb, logic inv);
    writeCfg(24'h0);
    bInv = inv; nearPins[2] = ~inv; step(2);
    writeCfg(mkCfg(TX, 2'b01, 3'b000, 4'b0000, inv ? 4'b1111 : 4'b0111, lenM1, msb));
  endtask

  task automatic runWord(string tag, logic [31:0] d, logic [4:0] lenM1, logic msb, logic inv);
    logic expBit, held;
    enterTx(lenM1, msb, inv);
    hostOut = 1'b1; hostDir = 1'b0;
    loadWord(d);
    chk({tag, " R5 oe override"}, pinOe, 1);
    for (int i = 0; i <= int'(lenM1); i++) begin
      expBit = msb ? d[int'(lenM1) - i] : d[i];
      chk({tag, " R6/R8 bit"}, pinOut, expBit);
      chk({tag, " R9 not done yet"}, statDone, 0);
      bFall();
      held = pinOut;
      bRise();
      chk({tag, " R7 rise keeps bit"}, pinOut, held);
    end
    chk({tag, " R9 done"}, statDone, 1);
    chk({tag, " R12 pinIn=done"}, pinIn, 1);
    chk({tag, " R9 holds last"}, pinOut, msb ? d[0] : d[lenM1]);
    hostOut = 1'b0;
  endtask

  task automatic testReset();
    hostOut = 1'b1; hostDir = 1'b1; step(1);
    chk("R1 reset done", statDone, 0);
    chk("R1 reset out", pinOut, 1);
    chk("R1 reset oe", pinOe, 1);
    hostOut = 1'b0; hostDir = 1'b0; step(1);
    chk("R1 off out follows", pinOut, 0);
    chk("R1 off oe follows", pinOe, 0);
  endtask

  task automatic testSelectors();
    logic [6:0] pats [2] = '{7'b1011001, 7'b0100110};
    for (int p = 0; p < 2; p++) begin
      for (int h = 0; h < 2; h++) begin
        nearPins = pats[p]; hostOut = h[0];
        for (int s = 0; s < 16; s++) begin
          writeCfg(mkCfg(5'd0, 2'b00, 3'b000, s[3:0], 4'b0000, 5'd0, 1'b0));
          chk(s[3] ? "R3 inverted select" : "R2 select", pinIn, selRef(s[3:0], pats[p], h[0]));
        end
      end
    end
    hostOut = 1'b0; nearPins = 7'b0000100;
  endtask

  task automatic testCombiner();
    logic a, b, e;
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 4; v++) begin
        a = v[0]; b = v[1];
        nearPins = {2'b00, b, a, 3'b100};
        writeCfg(mkCfg(5'd0, 2'b00, c[2:0], 4'b0000, 4'b0001, 5'd0, 1'b0));
        case (c)
          1: e = a & b;
          2: e = a | b;
          3: e = a ^ b;
          default: e = a;
        endcase
        chk("R4 combine", pinIn, e);
      end
    end
    nearPins = 7'b0000100;
  endtask

  task automatic testOverride();
    enterTx(5'd7, 1'b1, 1'b0);
    writeCfg(mkCfg(TX, 2'b00, 3'b000, 4'b0000, 4'b0111, 5'd7, 1'b1));
    hostDir = 1'b1; step(1);
    chk("R5 oe forced off", pinOe, 0);
    writeCfg(mkCfg(TX, 2'b01, 3'b000, 4'b0000, 4'b0111, 5'd7, 1'b1));
    hostDir = 1'b0; step(1);
    chk("R5 oe forced on", pinOe, 1);
    hostDir = 1'b0;
  endtask

  task automatic testBusyLoad();
    logic [7:0] d = 8'h71;
    enterTx(5'd7, 1'b1, 1'b0);
    loadWord(d);
    chk("R10 first bit", pinOut, d[7]);
    bFall(); bRise();
    loadWord(32'h0000_008E);
    chk("R10 busy load ignored", pinOut, d[6]);
    for (int i = 2; i < 8; i++) begin
      bFall(); bRise();
      chk("R10 sequence kept", pinOut, d[7 - i]);
    end
    bFall(); bRise();
    chk("R10 done", statDone, 1);
  endtask

  task automatic testClear();
    runWord("clr", 32'h5, 5'd2, 1'b0, 1'b0);
    step(3);
    chk("R11 done holds", statDone, 1);
    statRd = 1'b1; step(1); statRd = 1'b0;
    chk("R11 read clears", statDone, 0);
    chk("R12 pinIn follows", pinIn, 0);
    runWord("ack", 32'h2, 5'd1, 1'b1, 1'b0);
    statAck = 1'b1; step(1); statAck = 1'b0;
    chk("R11 ack clears", statDone, 0);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testSelectors();
    testCombiner();
    testOverride();
    runWord("R8 msb 71", 32'h71, 5'd7, 1'b1, 1'b0);
    runWord("R8 lsb 71", 32'h71, 5'd7, 1'b0, 1'b0);
    runWord("R9 len1", 32'h1, 5'd0, 1'b1, 1'b0);
    runWord("R9 len32 lsb", 32'hA5C3_0F96, 5'd31, 1'b0, 1'b0);
    runWord("R3 len32 msb inv clk", 32'h3C96_E1A7, 5'd31, 1'b1, 1'b1);
    testBusyLoad();
    testClear();
    writeCfg(24'h0); step(2);
    chk("R1 off again done", statDone, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule